// File: doc/BRIEF.md
# Asynchronous Error Logging and Trap Unit

This unit gathers error reports from a processor's memory and cache subsystem. Each report arrives as a one-cycle event that carries an error type, the privilege level of the access that caused it, and a flag that says whether an instruction fetch or a data access was involved. Every accepted event sets a sticky bit in a status register. A repeat of a non-correctable error class also sets a multiple-error flag, and an event from a privileged access also sets a privilege flag. Software clears the status register by writing ones to the bits it wants cleared.

A three-bit enable register decides what each error does beyond being logged. A correctable memory read error can raise a disrupting trap. The non-correctable group can raise an instruction-access or data-access trap. A cache tag parity error or a system address parity error can assert a fatal-error pulse. When the enable for a class is clear, the error is only logged. A correctable error seen while an interrupt vector is being sent is dropped: it is neither logged nor reported.

Both registers share one register port. The port reads combinationally and writes on the clock edge.

Top module: `err_log_unit`

## Requirements
- R1: The enable register is selected by `reg_sel`=0. Bit 0 enables the correctable class, bit 1 enables the non-correctable class and bit 2 enables address parity. Bits 63:3 read as zero and ignore writes.
- R2: Every accepted event sets the status bit 30 minus its type code, whatever the enables are. The type codes are 0 uncorrectable, 1 correctable, 2 time-out, 3 bus error, 4 buffer parity, 5 tag parity, 6 cache data parity, 7 write-buffer parity, 8 interrupt-vector uncorrectable, 9 address parity and 10 spare. Type codes 11 to 15 have no effect.
- R3: The status register is selected by `reg_sel`=1. A write clears each set bit among bits 32:20 whose write bit is one. Status bits 63:33 and 19:0 read as zero. When an event and a clearing write land in the same cycle, the event's bits (including any multiple-error flag it causes) stay set.
- R4: Status bit 32 sets when a non-correctable event arrives whose sticky bit is already set. A repeated correctable event, or events of different types, do not set it.
- R5: Status bit 31 sets when a logged event has `ev_priv`=1, and it stays set until it is cleared.
- R6: A correctable event with enable bit 0 set pulses `trap_corr`. A correctable event with `ev_ivec`=1 is neither logged nor trapped.
- R7: With enable bit 1 set, an event of type 0, 2, 3, 4, 6, 7 or 8 pulses `trap_iacc` if `ev_instr`=1 and `trap_dacc` otherwise.
- R8: `sys_fatal` pulses for a tag parity event when enable bit 1 is set, and for an address parity event when enable bit 2 is set.
- R9: Each trap or fatal output is high only in the one cycle after the clock edge that logs its event. At most one of them is high at a time, and none of them pulses when the matching enable is clear.
- R10: After reset the status register, the enable register and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Error event strobe |
| ev_type | input | 4 | Error type code |
| ev_priv | input | 1 | Event came from a privileged access |
| ev_instr | input | 1 | Event came from an instruction fetch |
| ev_ivec | input | 1 | Event occurred during interrupt vector transmission |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| trap_dacc | output | 1 | Data-access error trap pulse |
| trap_iacc | output | 1 | Instruction-access error trap pulse |
| trap_corr | output | 1 | Correctable-error disrupting trap pulse |
| sys_fatal | output | 1 | System fatal error pulse |

## Verification
Every type code is sent once with all enables clear. This shows that the sticky map follows the type code and that logging does not depend on the enables. Pairs of events follow: the same non-correctable type, the same correctable type, and two different types. These pairs separate a true multiple-error from a repeated correctable error and from errors of different classes. Each enable bit is then set on its own, and events with both values of the fetch flag show which output each class drives. A clearing write that collides with a new event shows that a set wins over a clear.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

   localparam int TYPE_W    = 4;
   localparam int NUM_TYPES = 11;

   typedef enum logic [TYPE_W-1:0] {
      ET_UNCORR   = 4'd0,
      ET_CORR     = 4'd1,
      ET_TIMEOUT  = 4'd2,
      ET_BUSERR   = 4'd3,
      ET_BUFPAR   = 4'd4,
      ET_TAGPAR   = 4'd5,
      ET_DATAPAR  = 4'd6,
      ET_WBPAR    = 4'd7,
      ET_IVUNCORR = 4'd8,
      ET_ADDRPAR  = 4'd9,
      ET_SPARE    = 4'd10
   } err_type_e;

   // decoded class of the current event
   typedef struct packed {
      logic log;
      logic is_corr;
      logic acc_grp;
      logic tag_par;
      logic addr_par;
   } err_class_t;

   // enable register bit positions
   localparam int EN_CORR = 0;
   localparam int EN_NC   = 1;
   localparam int EN_AP   = 2;
   localparam int EN_W    = 3;

endpackage

// File: rtl/err_classify.sv
module err_classify
   import err_log_pkg::*;
(
   input  logic                 ev_valid,
   input  logic [TYPE_W-1:0]    ev_type,
   input  logic                 ev_ivec,
   output logic [NUM_TYPES-1:0] hit,
   output err_class_t           cls
);

   logic accept;

   // a correctable error during interrupt vector transfer is dropped
   assign accept = ev_valid && (int'(ev_type) < NUM_TYPES) &&
                   !((ev_type == ET_CORR) && ev_ivec);

   for (genvar i = 0; i < NUM_TYPES; i++) begin : g_hit
      assign hit[i] = accept && (ev_type == TYPE_W'(i));
   end

   always_comb begin
      cls          = '0;
      cls.log      = accept;
      cls.is_corr  = hit[ET_CORR];
      cls.acc_grp  = hit[ET_UNCORR] | hit[ET_TIMEOUT] | hit[ET_BUSERR] |
                     hit[ET_BUFPAR] | hit[ET_DATAPAR] | hit[ET_WBPAR]  |
                     hit[ET_IVUNCORR];
      cls.tag_par  = hit[ET_TAGPAR];
      cls.addr_par = hit[ET_ADDRPAR];
   end

endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
   import err_log_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TYPES-1:0] hit,
   input  logic                 ev_log,
   input  logic                 ev_corr,
   input  logic                 ev_priv,
   input  logic [NUM_TYPES-1:0] clr_sticky,
   input  logic                 clr_priv,
   input  logic                 clr_me,
   output logic [NUM_TYPES-1:0] sticky_q,
   output logic                 priv_q,
   output logic                 me_q
);

   logic repeat_nc;

   // same class seen again, correctable errors excluded
   assign repeat_nc = (|(hit & sticky_q)) && !ev_corr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         priv_q   <= 1'b0;
         me_q     <= 1'b0;
      end else begin
         sticky_q <= (sticky_q & ~clr_sticky) | hit;
         priv_q   <= (priv_q & ~clr_priv) | (ev_log & ev_priv);
         me_q     <= (me_q & ~clr_me) | repeat_nc;
      end
   end

endmodule

// File: rtl/err_trap_gen.sv
module err_trap_gen
   import err_log_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  err_class_t      cls,
   input  logic            ev_instr,
   input  logic [EN_W-1:0] en,
   output logic            trap_dacc,
   output logic            trap_iacc,
   output logic            trap_corr,
   output logic            sys_fatal
);

   logic acc_fire;

   assign acc_fire = cls.acc_grp & en[EN_NC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_dacc <= 1'b0;
         trap_iacc <= 1'b0;
         trap_corr <= 1'b0;
         sys_fatal <= 1'b0;
      end else begin
         trap_dacc <= acc_fire & ~ev_instr;
         trap_iacc <= acc_fire &  ev_instr;
         trap_corr <= cls.is_corr & en[EN_CORR];
         sys_fatal <= (cls.tag_par & en[EN_NC]) | (cls.addr_par & en[EN_AP]);
      end
   end

endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
   import err_log_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int STICKY_TOP = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [3:0]        ev_type,
   input  logic              ev_priv,
   input  logic              ev_instr,
   input  logic              ev_ivec,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              trap_dacc,
   output logic              trap_iacc,
   output logic              trap_corr,
   output logic              sys_fatal
);

   localparam int STICKY_LO = STICKY_TOP - NUM_TYPES + 1;
   localparam int PRIV_BIT  = STICKY_TOP + 1;
   localparam int ME_BIT    = STICKY_TOP + 2;

   if (DATA_W < ME_BIT + 1) begin : g_bad_width
      $error("DATA_W too narrow for status layout");
   end
   if (STICKY_LO < EN_W) begin : g_bad_layout
      $error("STICKY_TOP too small for the sticky field");
   end

   logic [EN_W-1:0]      en_q;
   logic [NUM_TYPES-1:0] hit, sticky_q, clr_sticky;
   logic                 priv_q, me_q, wr_stat;
   err_class_t           cls;
   logic [DATA_W-1:0]    status_vec;

   assign wr_stat = reg_wr && reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q <= '0;
      else if (reg_wr && !reg_sel) en_q <= reg_wdata[EN_W-1:0];
   end

   for (genvar i = 0; i < NUM_TYPES; i++) begin : g_map
      assign clr_sticky[i] = wr_stat & reg_wdata[STICKY_TOP-i];
   end

   always_comb begin
      status_vec         = '0;
      status_vec[ME_BIT]   = me_q;
      status_vec[PRIV_BIT] = priv_q;
      for (int i = 0; i < NUM_TYPES; i++) status_vec[STICKY_TOP-i] = sticky_q[i];
   end

   assign reg_rdata = reg_sel ? status_vec : {{(DATA_W-EN_W){1'b0}}, en_q};

   err_classify u_cls (
      .ev_valid (ev_valid),
      .ev_type  (ev_type),
      .ev_ivec  (ev_ivec),
      .hit      (hit),
      .cls      (cls)
   );

   err_status_reg u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .ev_log     (cls.log),
      .ev_corr    (cls.is_corr),
      .ev_priv    (ev_priv),
      .clr_sticky (clr_sticky),
      .clr_priv   (wr_stat & reg_wdata[PRIV_BIT]),
      .clr_me     (wr_stat & reg_wdata[ME_BIT]),
      .sticky_q   (sticky_q),
      .priv_q     (priv_q),
      .me_q       (me_q)
   );

   err_trap_gen u_trap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cls       (cls),
      .ev_instr  (ev_instr),
      .en        (en_q),
      .trap_dacc (trap_dacc),
      .trap_iacc (trap_iacc),
      .trap_corr (trap_corr),
      .sys_fatal (sys_fatal)
   );

endmodule

// File: rtl/err_log_chk.sv
module err_log_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic [3:0]        ev_type,
   input logic              ev_ivec,
   input logic              reg_wr,
   input logic              reg_sel,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              trap_dacc,
   input logic              trap_iacc,
   input logic              trap_corr,
   input logic              sys_fatal,
   input logic [2:0]        en_q,
   input logic [DATA_W-1:0] status
);

   // R9
   quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !(trap_dacc | trap_iacc | trap_corr | sys_fatal));

   // R9
   single_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_dacc, trap_iacc, trap_corr, sys_fatal}));

   // R6
   ivec_corr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_type == 4'd1 && ev_ivec) |=> !trap_corr);

   // R2
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_type < 4'd11 && !(ev_type == 4'd1 && ev_ivec))
      |=> status[30 - int'($past(ev_type))]);

   // R3
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid && !reg_wr) |=> $stable(status));

   // R1
   en_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (reg_rdata[DATA_W-1:3] == '0));

   // R8
   fatal_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_fatal |-> ($past(en_q[1]) || $past(en_q[2])));

endmodule

bind err_log_unit err_log_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ev_type   (ev_type),
   .ev_ivec   (ev_ivec),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_rdata (reg_rdata),
   .trap_dacc (trap_dacc),
   .trap_iacc (trap_iacc),
   .trap_corr (trap_corr),
   .sys_fatal (sys_fatal),
   .en_q      (en_q),
   .status    (status_vec)
);

// File: tb/err_log_unit_test.sv
module err_log_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [3:0]  ev_type = '0;
   logic        ev_priv = 1'b0, ev_instr = 1'b0, ev_ivec = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        trap_dacc, trap_iacc, trap_corr, sys_fatal;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   err_log_unit uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type),
      .ev_priv(ev_priv), .ev_instr(ev_instr), .ev_ivec(ev_ivec),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .trap_dacc(trap_dacc), .trap_iacc(trap_iacc),
      .trap_corr(trap_corr), .sys_fatal(sys_fatal)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [63:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic sel, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // send one event; outs = {dacc, iacc, corr, fatal} in the cycle after logging
   task automatic send(input logic [3:0] t, input logic p, input logic ins,
                       input logic iv, output logic [3:0] outs);
      @(negedge clk);
      ev_valid = 1'b1; ev_type = t; ev_priv = p; ev_instr = ins; ev_ivec = iv;
      @(negedge clk);
      ev_valid = 1'b0; ev_priv = 1'b0; ev_instr = 1'b0; ev_ivec = 1'b0;
      outs = {trap_dacc, trap_iacc, trap_corr, sys_fatal};
      @(negedge clk);
      chk("R9 pulse ends", {60'd0, trap_dacc, trap_iacc, trap_corr, sys_fatal}, 64'd0);
   endtask

   function automatic logic [63:0] sbit(input int t);
      return 64'd1 << (30 - t);
   endfunction

   task automatic t_reset();
      logic [63:0] v;
      rd(1'b1, v); chk("R10 status", v, 64'd0);
      rd(1'b0, v); chk("R10 enable", v, 64'd0);
      chk("R10 outputs", {60'd0, trap_dacc, trap_iacc, trap_corr, sys_fatal}, 64'd0);
   endtask

   task automatic t_enable_reg();
      logic [63:0] v;
      wr(1'b0, '1);
      rd(1'b0, v); chk("R1 enable all ones", v, 64'h7);
      wr(1'b0, 64'hFFFF_0000_0000_0005);
      rd(1'b0, v); chk("R1 enable reserved", v, 64'h5);
      wr(1'b0, 64'd0);
   endtask

   task automatic t_sticky_map();
      logic [63:0] v;
      logic [3:0]  o;
      for (int t = 0; t < 11; t++) begin
         send(4'(t), 1'b0, 1'b0, 1'b0, o);
         chk("R9 no output when disabled", {60'd0, o}, 64'd0);
         rd(1'b1, v); chk("R2 sticky position", v, sbit(t));
         wr(1'b1, '1);
         rd(1'b1, v); chk("R3 clear all", v, 64'd0);
      end
      send(4'd12, 1'b1, 1'b0, 1'b0, o);
      rd(1'b1, v); chk("R2 unused type ignored", v, 64'd0);
   endtask

   task automatic t_multi();
      logic [63:0] v;
      logic [3:0]  o;
      send(4'd0, 1'b0, 1'b0, 1'b0, o);
      send(4'd0, 1'b0, 1'b0, 1'b0, o);
      rd(1'b1, v); chk("R4 repeat uncorrectable", v, sbit(0) | (64'd1 << 32));
      wr(1'b1, '1);
      send(4'd1, 1'b0, 1'b0, 1'b0, o);
      send(4'd1, 1'b0, 1'b0, 1'b0, o);
      rd(1'b1, v); chk("R4 repeat correctable", v, sbit(1));
      wr(1'b1, '1);
      send(4'd0, 1'b0, 1'b0, 1'b0, o);
      send(4'd2, 1'b0, 1'b0, 1'b0, o);
      rd(1'b1, v); chk("R4 different types", v, sbit(0) | sbit(2));
      wr(1'b1, '1);
   endtask

   task automatic t_priv();
      logic [63:0] v;
      logic [3:0]  o;
      send(4'd2, 1'b1, 1'b0, 1'b0, o);
      send(4'd3, 1'b0, 1'b0, 1'b0, o);
      rd(1'b1, v); chk("R5 privilege kept", v, sbit(2) | sbit(3) | (64'd1 << 31));
      wr(1'b1, 64'd1 << 31);
      rd(1'b1, v); chk("R3 partial clear", v, sbit(2) | sbit(3));
      wr(1'b1, '1);
   endtask

   task automatic t_corr();
      logic [63:0] v;
      logic [3:0]  o;
      wr(1'b0, 64'h1);
      send(4'd1, 1'b0, 1'b0, 1'b0, o);
      chk("R6 correctable trap", {60'd0, o}, 64'b0010);
      wr(1'b1, '1);
      send(4'd1, 1'b1, 1'b0, 1'b1, o);
      chk("R6 ivec no trap", {60'd0, o}, 64'd0);
      rd(1'b1, v); chk("R6 ivec not logged", v, 64'd0);
      send(4'd0, 1'b0, 1'b0, 1'b0, o);
      chk("R9 access trap disabled", {60'd0, o}, 64'd0);
      wr(1'b1, '1);
   endtask

   task automatic t_access();
      logic [3:0] o;
      wr(1'b0, 64'h2);
      send(4'd0, 1'b0, 1'b0, 1'b0, o);
      chk("R7 data access trap", {60'd0, o}, 64'b1000);
      send(4'd3, 1'b0, 1'b1, 1'b0, o);
      chk("R7 instruction access trap", {60'd0, o}, 64'b0100);
      send(4'd7, 1'b0, 1'b0, 1'b0, o);
      chk("R7 write-buffer parity trap", {60'd0, o}, 64'b1000);
      send(4'd5, 1'b0, 1'b0, 1'b0, o);
      chk("R8 tag parity fatal", {60'd0, o}, 64'b0001);
      send(4'd9, 1'b0, 1'b0, 1'b0, o);
      chk("R8 address parity disabled", {60'd0, o}, 64'd0);
      send(4'd1, 1'b0, 1'b0, 1'b0, o);
      chk("R9 correctable disabled", {60'd0, o}, 64'd0);
      wr(1'b0, 64'h4);
      send(4'd9, 1'b0, 1'b0, 1'b0, o);
      chk("R8 address parity fatal", {60'd0, o}, 64'b0001);
      send(4'd5, 1'b0, 1'b0, 1'b0, o);
      chk("R8 tag parity disabled", {60'd0, o}, 64'd0);
      wr(1'b0, 64'd0);
      wr(1'b1, '1);
   endtask

   task automatic t_collide();
      logic [63:0] v;
      logic [3:0]  o;
      send(4'd2, 1'b0, 1'b0, 1'b0, o);
      @(negedge clk);
      ev_valid = 1'b1; ev_type = 4'd2;
      reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = '1;
      @(negedge clk);
      ev_valid = 1'b0; reg_wr = 1'b0;
      rd(1'b1, v); chk("R3 event wins over clear", v, sbit(2) | (64'd1 << 32));
      wr(1'b1, '1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_reg();
      t_sticky_map();
      t_multi();
      t_priv();
      t_corr();
      t_access();
      t_collide();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule